// File: doc/BRIEF.md
# Clock-Gating Power State Controller

This block steps a processor-style core through three nested power levels: full run, a stop-grant level, and a sleep level. A stop-clock request and a sleep request, both active-low and both free to change at any moment with no relation to the block clock, are passed through a synchronizer before a small state machine acts on them. From the current level the block drives clock enables for the core units, for the bus unit, for the interrupt-controller unit and for the PLL. It also drives a flag that allows snooping and a flag that turns incoming interrupts into a pending latch instead of servicing them.

The stop-grant level can only be entered from full run, and sleep can only be entered from stop-grant. Entering stop-grant issues a one-cycle acknowledge request toward the bus logic. Leaving stop-grant for full run issues a one-cycle resume-service pulse when an interrupt was latched during the stop. An active-low reset returns the block to full run from any level and clears the latch.

Top module: `pwr_state_ctrl`

## Requirements
- R1: With the block at full run, asserting stop_clk_n (low) moves it to stop-grant and raises sg_ack_req for exactly one cycle per entry.
- R2: In stop-grant every bit of core_clk_en is 0, while bus_clk_en, intc_clk_en and pll_clk_en are 1.
- R3: In stop-grant snoop_en and irq_latch_en are 1, and a one-cycle irq_i pulse sets irq_pending.
- R4: In stop-grant, asserting sleep_n (low) moves the block to sleep, where core_clk_en, bus_clk_en and intc_clk_en are all 0 and pll_clk_en stays 1.
- R5: In sleep snoop_en and irq_latch_en are 0, irq_i pulses leave irq_pending unchanged, and deasserting stop_clk_n while sleep_n is still low keeps the block in sleep.
- R6: In sleep, deasserting sleep_n (high) returns the block to stop-grant, turning bus_clk_en and intc_clk_en back on.
- R7: In stop-grant, deasserting stop_clk_n (high) returns the block to full run with every enable at 1 and clears irq_pending; resume_svc pulses for one cycle if and only if irq_pending was set. This exit wins over a simultaneous sleep request.
- R8: Asserting sleep_n while at full run is ignored.
- R9: While rst_n is low the block is at full run: all clock enables and snoop_en are 1, irq_latch_en, irq_pending, sg_ack_req and resume_svc are 0, from whatever level it was in.
- R10: With the default SYNC_STAGES of 2, a change of stop_clk_n set up before clock edge 0 changes the registered clock enables at edge 3 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_clk_n | input | 1 | Asynchronous active-low stop-clock request |
| sleep_n | input | 1 | Asynchronous active-low sleep request |
| irq_i | input | 1 | Synchronous interrupt arrival strobe |
| core_clk_en | output | NUM_CORE_UNITS | Clock enables for the core units |
| bus_clk_en | output | 1 | Clock enable for the bus unit |
| intc_clk_en | output | 1 | Clock enable for the interrupt-controller unit |
| pll_clk_en | output | 1 | PLL run enable |
| sg_ack_req | output | 1 | One-cycle request to issue a stop-grant acknowledge |
| snoop_en | output | 1 | Snooping allowed |
| irq_latch_en | output | 1 | Interrupts are latched as pending rather than serviced |
| resume_svc | output | 1 | One-cycle request to service latched interrupts |
| irq_pending | output | 1 | An interrupt was latched during stop-grant |

## Verification
The bench sweeps every pair of request levels from each of the three levels and compares the settled enables and pulse counts with a small arithmetic model. A controller that allowed sleep from full run, or let a stop-clock release escape sleep, ends in the wrong enable pattern. Interrupts are pulsed in stop-grant, in sleep and at full run: a design that latched in sleep or at full run, or that failed to clear the latch on exit or on reset, gives a wrong resume_svc count or a stale irq_pending. A latency probe catches a synchronizer with a missing or extra stage.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
   typedef enum logic [1:0] {
      PS_RUN   = 2'd0,
      PS_GRANT = 2'd1,
      PS_DOZE  = 2'd2
   } psc_state_e;
endpackage

// File: rtl/psc_sync.sv
module psc_sync #(
   parameter int  STAGES  = 2,
   parameter bit  RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("psc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RST_VAL;
               else        chain_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RST_VAL;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/psc_fsm.sv
module psc_fsm
   import pwr_state_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_req,
   input  logic       sleep_req,
   input  logic       irq_i,
   output psc_state_e state_o,
   output logic       ack_o,
   output logic       resume_o,
   output logic       pend_o
);
   psc_state_e state_q, state_d;
   logic       ack_d, resume_d, pend_q, pend_d;

   always_comb begin
      state_d  = state_q;
      ack_d    = 1'b0;
      resume_d = 1'b0;
      pend_d   = pend_q;
      unique case (state_q)
         PS_RUN: begin
            if (stop_req) begin
               state_d = PS_GRANT;
               ack_d   = 1'b1;
            end
         end
         PS_GRANT: begin
            if (!stop_req) begin
               state_d  = PS_RUN;
               resume_d = pend_q;
               pend_d   = 1'b0;
            end else begin
               pend_d = pend_q | irq_i;
               if (sleep_req) state_d = PS_DOZE;
            end
         end
         PS_DOZE: begin
            if (!sleep_req) state_d = PS_GRANT;
         end
         default: state_d = PS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= PS_RUN;
         ack_o    <= 1'b0;
         resume_o <= 1'b0;
         pend_q   <= 1'b0;
      end else begin
         state_q  <= state_d;
         ack_o    <= ack_d;
         resume_o <= resume_d;
         pend_q   <= pend_d;
      end
   end

   assign state_o = state_q;
   assign pend_o  = pend_q;
endmodule

// File: rtl/psc_outdec.sv
module psc_outdec
   import pwr_state_pkg::*;
#(
   parameter int NUM_CORE_UNITS = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  psc_state_e                state_i,
   output logic [NUM_CORE_UNITS-1:0] core_en_o,
   output logic                      bus_en_o,
   output logic                      intc_en_o,
   output logic                      pll_en_o,
   output logic                      snoop_o,
   output logic                      latch_o
);
   logic run_lvl, awake_lvl;

   assign run_lvl   = (state_i == PS_RUN);
   assign awake_lvl = (state_i != PS_DOZE);

   generate
      for (genvar u = 0; u < NUM_CORE_UNITS; u++) begin : g_core
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) core_en_o[u] <= 1'b1;
            else        core_en_o[u] <= run_lvl;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_en_o  <= 1'b1;
         intc_en_o <= 1'b1;
         pll_en_o  <= 1'b1;
         snoop_o   <= 1'b1;
         latch_o   <= 1'b0;
      end else begin
         bus_en_o  <= awake_lvl;
         intc_en_o <= awake_lvl;
         pll_en_o  <= 1'b1;
         snoop_o   <= awake_lvl;
         latch_o   <= (state_i == PS_GRANT);
      end
   end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
   import pwr_state_pkg::*;
#(
   parameter int NUM_CORE_UNITS = 3,
   parameter int SYNC_STAGES    = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      stop_clk_n,
   input  logic                      sleep_n,
   input  logic                      irq_i,
   output logic [NUM_CORE_UNITS-1:0] core_clk_en,
   output logic                      bus_clk_en,
   output logic                      intc_clk_en,
   output logic                      pll_clk_en,
   output logic                      sg_ack_req,
   output logic                      snoop_en,
   output logic                      irq_latch_en,
   output logic                      resume_svc,
   output logic                      irq_pending
);
   generate
      if (NUM_CORE_UNITS < 1) begin : g_bad_units
         $error("pwr_state_ctrl: NUM_CORE_UNITS must be at least 1");
      end
   endgenerate

   logic       stop_sync_n, sleep_sync_n;
   psc_state_e cur_state;

   psc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_stop (
      .clk(clk), .rst_n(rst_n), .async_i(stop_clk_n), .sync_o(stop_sync_n));

   psc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sleep (
      .clk(clk), .rst_n(rst_n), .async_i(sleep_n), .sync_o(sleep_sync_n));

   psc_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .stop_req(!stop_sync_n), .sleep_req(!sleep_sync_n), .irq_i(irq_i),
      .state_o(cur_state), .ack_o(sg_ack_req), .resume_o(resume_svc),
      .pend_o(irq_pending));

   psc_outdec #(.NUM_CORE_UNITS(NUM_CORE_UNITS)) u_outdec (
      .clk(clk), .rst_n(rst_n), .state_i(cur_state),
      .core_en_o(core_clk_en), .bus_en_o(bus_clk_en), .intc_en_o(intc_clk_en),
      .pll_en_o(pll_clk_en), .snoop_o(snoop_en), .latch_o(irq_latch_en));
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk #(
   parameter int NUM_CORE_UNITS = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_CORE_UNITS-1:0] core_clk_en,
   input logic                      bus_clk_en,
   input logic                      intc_clk_en,
   input logic                      sg_ack_req,
   input logic                      snoop_en,
   input logic                      irq_latch_en,
   input logic                      resume_svc,
   input logic                      irq_pending
);
   p_ack_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sg_ack_req |=> !sg_ack_req);

   p_ack_from_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sg_ack_req |-> (&core_clk_en));

   p_core_needs_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|core_clk_en) |-> (bus_clk_en && intc_clk_en));

   p_latch_in_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pending) |-> irq_latch_en);

   p_sleep_from_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_clk_en) |-> (core_clk_en == '0));

   p_sleep_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_clk_en |-> (!snoop_en && !irq_latch_en));

   p_resume_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resume_svc |-> ($past(irq_pending) && !irq_pending));
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(.NUM_CORE_UNITS(NUM_CORE_UNITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
   .intc_clk_en(intc_clk_en), .sg_ack_req(sg_ack_req), .snoop_en(snoop_en),
   .irq_latch_en(irq_latch_en), .resume_svc(resume_svc), .irq_pending(irq_pending));

// File: tb/pwr_state_ctrl_tb_top.sv
module pwr_state_ctrl_tb_top;
   localparam int NU = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stop_clk_n = 1'b1;
   logic          sleep_n = 1'b1;
   logic          irq_i = 1'b0;
   logic [NU-1:0] core_clk_en;
   logic          bus_clk_en, intc_clk_en, pll_clk_en, sg_ack_req;
   logic          snoop_en, irq_latch_en, resume_svc, irq_pending;

   int checks = 0;
   int errors = 0;
   int ack_seen = 0;
   int res_seen = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pwr_state_ctrl #(.NUM_CORE_UNITS(NU), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .stop_clk_n(stop_clk_n), .sleep_n(sleep_n),
      .irq_i(irq_i), .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
      .intc_clk_en(intc_clk_en), .pll_clk_en(pll_clk_en), .sg_ack_req(sg_ack_req),
      .snoop_en(snoop_en), .irq_latch_en(irq_latch_en), .resume_svc(resume_svc),
      .irq_pending(irq_pending));

   always @(negedge clk) begin
      if (rst_n && sg_ack_req) ack_seen++;
      if (rst_n && resume_svc) res_seen++;
   end

   // level code: 0 run, 1 stop-grant, 2 sleep
   function automatic logic [5:0] lvl_pattern(int lvl);
      // {core all on, core all off, bus, intc, pll, snoop}
      case (lvl)
         0:       return 6'b101111;
         1:       return 6'b011111;
         default: return 6'b010010;
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_level(string req, int lvl);
      logic [5:0] act;
      act = {&core_clk_en, ~|core_clk_en, bus_clk_en, intc_clk_en, pll_clk_en, snoop_en};
      chk(req, {26'd0, act}, {26'd0, lvl_pattern(lvl)});
      chk({req, " latch"}, {31'd0, irq_latch_en}, {31'd0, (lvl == 1)});
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cyc(2);
      rst_n = 1'b1;
      ack_seen = 0;
      res_seen = 0;
   endtask

   task automatic set_in(logic stp, logic slp);
      stop_clk_n = stp;
      sleep_n    = slp;
   endtask

   task automatic pulse_irq();
      irq_i = 1'b1;
      cyc(1);
      irq_i = 1'b0;
   endtask

   // model: settle the level for active-high requests
   task automatic model(inout int lvl, input bit stp, input bit slp,
                        inout int acks);
      for (int k = 0; k < 4; k++) begin
         case (lvl)
            0: if (stp) begin lvl = 1; acks++; end
            1: if (!stp) lvl = 0; else if (slp) lvl = 2;
            default: if (!slp) lvl = 1;
         endcase
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R9: reset values while rst_n is low
      cyc(1);
      chk_level("R9 reset level", 0);
      chk("R9 reset pending", {31'd0, irq_pending}, 32'd0);
      chk("R9 reset pulses", {30'd0, sg_ack_req, resume_svc}, 32'd0);
      rst_n = 1'b1;
      cyc(2);

      // R10: latency of the synchronizer and enable registers
      do_reset();
      set_in(1'b0, 1'b1);
      cyc(3);
      chk("R10 enables still on after 3 edges", {31'd0, &core_clk_en}, 32'd1);
      cyc(1);
      chk("R10 enables off after 4th edge", {31'd0, |core_clk_en}, 32'd0);
      cyc(4);

      // sweep: every start level x every request pair (R1 R2 R4 R5 R6 R7 R8)
      for (int st = 0; st < 3; st++) begin
         for (int pr = 0; pr < 4; pr++) begin
            int lvl, acks;
            bit a_stp, a_slp;
            string tag;
            a_stp = pr[0];
            a_slp = pr[1];
            lvl = 0;
            acks = 0;
            do_reset();
            if (st >= 1) begin set_in(1'b0, 1'b1); model(lvl, 1'b1, 1'b0, acks); cyc(8); end
            if (st == 2) begin set_in(1'b0, 1'b0); model(lvl, 1'b1, 1'b1, acks); cyc(8); end
            set_in(!a_stp, !a_slp);
            model(lvl, a_stp, a_slp, acks);
            cyc(10);
            case (st)
               0: tag = a_slp && !a_stp ? "R8 sleep ignored at run" : "R1 R4 from run";
               1: tag = !a_stp ? "R7 exit wins" : "R2 R4 from grant";
               default: tag = a_slp ? "R5 sleep holds" : "R6 wake to grant";
            endcase
            chk_level(tag, lvl);
            chk({tag, " R1 ack count"}, ack_seen, acks);
            chk({tag, " R7 no resume"}, res_seen, 0);
         end
      end

      // R3 R7: interrupt latched in stop-grant, serviced once on exit
      do_reset();
      set_in(1'b0, 1'b1);
      cyc(8);
      chk_level("R2 grant level", 1);
      pulse_irq();
      cyc(1);
      chk("R3 pending set in grant", {31'd0, irq_pending}, 32'd1);
      set_in(1'b1, 1'b1);
      cyc(8);
      chk("R7 resume pulse count", res_seen, 1);
      chk("R7 pending cleared", {31'd0, irq_pending}, 32'd0);
      chk_level("R7 back at run", 0);

      // R5: interrupt in sleep ignored, no resume on exit
      do_reset();
      set_in(1'b0, 1'b1);
      cyc(8);
      set_in(1'b0, 1'b0);
      cyc(8);
      pulse_irq();
      cyc(1);
      chk("R5 pending untouched in sleep", {31'd0, irq_pending}, 32'd0);
      set_in(1'b0, 1'b1);
      cyc(8);
      chk("R6 pending after wake", {31'd0, irq_pending}, 32'd0);
      set_in(1'b1, 1'b1);
      cyc(8);
      chk("R5 no resume after sleep irq", res_seen, 0);

      // R8 with interrupt: nothing latched at run
      do_reset();
      pulse_irq();
      cyc(2);
      chk("R8 no pending at run", {31'd0, irq_pending}, 32'd0);

      // R9: reset from stop-grant with pending and from sleep
      do_reset();
      set_in(1'b0, 1'b1);
      cyc(8);
      pulse_irq();
      cyc(1);
      chk("R3 pending before reset", {31'd0, irq_pending}, 32'd1);
      rst_n = 1'b0;
      cyc(1);
      chk("R9 pending cleared by reset", {31'd0, irq_pending}, 32'd0);
      chk_level("R9 run level in reset", 0);
      set_in(1'b0, 1'b0);
      rst_n = 1'b1;
      cyc(8);
      chk_level("R4 sleep after re-entry", 2);
      rst_n = 1'b0;
      cyc(1);
      chk_level("R9 reset from sleep", 0);
      set_in(1'b1, 1'b1);
      rst_n = 1'b1;
      cyc(4);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule